// File: doc/BRIEF.md
# Chunked Memory Bank Selector

This block sits between a CPU's 16-bit address bus and three memory banks. It splits the 64 KB address space into eight 8 KB chunks and, for every memory request, decides which bank answers. The default bank is Home. Any chunk can instead be given to one alternate bank, which is either the Extension bank or the Dock (cartridge) bank.

Software sets the mapping with two I/O port writes. A chunk-route register holds one bit per chunk, and a bit set to 1 takes that chunk away from Home. A one-bit source register then picks Extension or Dock for every chunk that is taken away. Both registers clear at reset, so the CPU starts from Home across the whole address space. The block drives one chip-enable per bank and passes on the 13-bit offset inside the chunk.

Top module: `chunk_bank_sel`

## Requirements
- R1: After reset the route register is 0, and every memory request enables Home until a route write changes this.
- R2: The chunk number is addr[15:13], and the offset output always equals addr[12:0].
- R3: A memory request to chunk i enables Home when bit i of the route register is 0. It enables the alternate bank when that bit is 1.
- R4: Bit 0 of the last byte written to the source port picks the alternate bank (0 = Extension, 1 = Dock). It applies to every routed chunk at once. Bits 7:1 of that byte have no effect.
- R5: While mem_req is 1, exactly one of ce_home, ce_ext and ce_dock is 1. While mem_req is 0, all three are 0.
- R6: A write with io_wr=1 is taken at the rising clock edge that samples it. A memory request in that same cycle still uses the old mapping, and the new mapping applies from the next cycle on. The enables change only when addr, mem_req or a register changes.
- R7: Writes whose io_addr matches neither ROUTE_PORT (default 8'h40) nor SRC_PORT (default 8'h41) change no mapping.
- R8: With a route value of 8'hFF and Dock selected, all eight chunks are served by Dock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| mem_req | input | 1 | Memory request active |
| addr | input | 16 | CPU memory address |
| ce_home | output | 1 | Home bank enable |
| ce_ext | output | 1 | Extension bank enable |
| ce_dock | output | 1 | Dock bank enable |
| offset | output | 13 | Offset within the 8 KB chunk |

## Verification
A register write and a memory access can fall in the same cycle. The bench provokes this by raising io_wr and mem_req together while the address points into the chunk that the write re-routes. It then checks that the enable still shows the old bank before the edge and the new bank after it. A separate set of cases changes the source register while routed chunks are being accessed. These checks confirm that every routed chunk moves between Extension and Dock at the same moment.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
    parameter int ADDR_W  = 16;
    parameter int CHUNK_W = 3;
    localparam int NCHUNK = 1 << CHUNK_W;
    localparam int OFS_W  = ADDR_W - CHUNK_W;

    typedef struct packed {
        logic [NCHUNK-1:0] route;
        logic              use_dock;
    } map_state_t;
endpackage

// File: rtl/cbs_regfile.sv
module cbs_regfile
    import cbs_pkg::*;
#(
    parameter int          IO_W       = 8,
    parameter logic [7:0]  ROUTE_PORT = 8'h40,
    parameter logic [7:0]  SRC_PORT   = 8'h41
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            io_wr,
    input  logic [IO_W-1:0] io_addr,
    input  logic [IO_W-1:0] io_wdata,
    output map_state_t      map_o
);
    map_state_t st_d, st_q;
    logic unused_hi;

    assign unused_hi = ^io_wdata[IO_W-1:1];

    always_comb begin
        st_d = st_q;
        if (io_wr && io_addr == ROUTE_PORT[IO_W-1:0])
            st_d.route = io_wdata[NCHUNK-1:0];
        if (io_wr && io_addr == SRC_PORT[IO_W-1:0])
            st_d.use_dock = io_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign map_o = st_q;
endmodule

// File: rtl/cbs_decode.sv
module cbs_decode
    import cbs_pkg::*;
(
    input  logic              mem_req,
    input  logic [ADDR_W-1:0] addr,
    input  map_state_t        map_i,
    output logic              ce_home,
    output logic              ce_ext,
    output logic              ce_dock,
    output logic [OFS_W-1:0]  offset
);
    logic [NCHUNK-1:0] hit;
    logic              routed;

    for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
        assign hit[i] = (addr[ADDR_W-1:OFS_W] == CHUNK_W'(i)) && map_i.route[i];
    end

    always_comb begin
        routed  = |hit;
        ce_home = mem_req && !routed;
        ce_ext  = mem_req && routed && !map_i.use_dock;
        ce_dock = mem_req && routed && map_i.use_dock;
        offset  = addr[OFS_W-1:0];
    end
endmodule

// File: rtl/chunk_bank_sel.sv
module chunk_bank_sel
    import cbs_pkg::*;
#(
    parameter logic [7:0] ROUTE_PORT = 8'h40,
    parameter logic [7:0] SRC_PORT   = 8'h41
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_wr,
    input  logic [7:0]  io_addr,
    input  logic [7:0]  io_wdata,
    input  logic        mem_req,
    input  logic [15:0] addr,
    output logic        ce_home,
    output logic        ce_ext,
    output logic        ce_dock,
    output logic [12:0] offset
);
    map_state_t map_q;

    cbs_regfile #(.IO_W(8), .ROUTE_PORT(ROUTE_PORT), .SRC_PORT(SRC_PORT)) u_regs (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .map_o(map_q)
    );

    cbs_decode u_dec (
        .mem_req(mem_req), .addr(addr), .map_i(map_q),
        .ce_home(ce_home), .ce_ext(ce_ext), .ce_dock(ce_dock), .offset(offset)
    );
endmodule

// File: rtl/cbs_check.sv
module cbs_check (
    input logic        clk,
    input logic        rst_n,
    input logic        io_wr,
    input logic        mem_req,
    input logic [15:0] addr,
    input logic        ce_home,
    input logic        ce_ext,
    input logic        ce_dock
);
    logic wrote_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     wrote_q <= 1'b0;
        else if (io_wr) wrote_q <= 1'b1;
    end

    // R5
    one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $countones({ce_home, ce_ext, ce_dock}) == 1);

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> !(ce_home || ce_ext || ce_dock));

    // R1
    reset_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrote_q && mem_req) |-> ce_home);

    // R6
    no_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(io_wr) && $stable(addr) && $stable(mem_req))
        |-> ($stable(ce_home) && $stable(ce_ext) && $stable(ce_dock)));
endmodule

bind chunk_bank_sel cbs_check u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .mem_req(mem_req), .addr(addr),
    .ce_home(ce_home), .ce_ext(ce_ext), .ce_dock(ce_dock)
);

// File: tb/tb_chunk_bank_sel.sv
module tb_chunk_bank_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        mem_req = 1'b0;
    logic [15:0] addr = '0;
    logic        ce_home, ce_ext, ce_dock;
    logic [12:0] offset;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    localparam logic [7:0] RP = 8'h40;
    localparam logic [7:0] SP = 8'h41;

    always #2 clk = ~clk;

    chunk_bank_sel dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .mem_req(mem_req), .addr(addr),
        .ce_home(ce_home), .ce_ext(ce_ext), .ce_dock(ce_dock), .offset(offset)
    );

    // expected enables as {home, ext, dock}
    task automatic chk(input string req, input logic [2:0] exp);
        checks++;
        if ({ce_home, ce_ext, ce_dock} !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b (addr %h)", req,
                     {ce_home, ce_ext, ce_dock}, exp, addr);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic access(input logic [15:0] a);
        @(negedge clk);
        mem_req = 1'b1; addr = a;
        #1;
    endtask

    task automatic t_reset;
        for (int c = 0; c < 8; c++) begin
            access(16'(c) << 13 | 16'h0123);
            chk("R1", 3'b100);
        end
        @(negedge clk); mem_req = 1'b0; #1;
        chk("R5", 3'b000);
    endtask

    task automatic t_offset;
        access(16'hB5A7);
        checks++;
        if (offset !== 13'h15A7) begin
            fails++;
            $display("FAIL R2: got %h expected %h", offset, 13'h15A7);
        end
    endtask

    task automatic t_route_ext;
        io_write(SP, 8'h00);
        io_write(RP, 8'b0010_0100);
        for (int c = 0; c < 8; c++) begin
            access(16'(c) << 13);
            chk("R3", (c == 2 || c == 5) ? 3'b010 : 3'b100);
        end
    endtask

    task automatic t_source_flip;
        io_write(SP, 8'hFE);
        access(16'h4000); chk("R4", 3'b010);
        io_write(SP, 8'h01);
        access(16'h4000); chk("R4", 3'b001);
        access(16'hA000); chk("R4", 3'b001);
        access(16'h0000); chk("R4", 3'b100);
    endtask

    task automatic t_same_cycle;
        io_write(RP, 8'h00);
        @(negedge clk);
        mem_req = 1'b1; addr = 16'h6010;
        io_wr = 1'b1; io_addr = RP; io_wdata = 8'h08;
        #1; chk("R6", 3'b100);
        @(negedge clk);
        io_wr = 1'b0;
        #1; chk("R6", 3'b001);
    endtask

    task automatic t_other_port;
        io_write(8'h42, 8'h00);
        io_write(8'hC0, 8'hFF);
        access(16'h6000); chk("R7", 3'b001);
        access(16'h0000); chk("R7", 3'b100);
    endtask

    task automatic t_full_dock;
        io_write(RP, 8'hFF);
        for (int c = 0; c < 8; c++) begin
            access(16'(c) << 13 | 16'h1FFF);
            chk("R8", 3'b001);
        end
    endtask

    task automatic t_idle;
        @(negedge clk); mem_req = 1'b0; #1;
        chk("R5", 3'b000);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_offset();
        t_route_ext();
        t_source_flip();
        t_same_cycle();
        t_other_port();
        t_full_dock();
        t_idle();
        done = 1'b1;
        finish_up();
    end
endmodule